// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer for 9-bit words. The depth is a power of two set by a parameter. A write port and a read port each have their own clock. The two clocks may also be tied together, and a build parameter then removes the clock-crossing stages. Four active-low flags report the fill state:

- empty and almost-empty, computed in the read clock domain;
- full and almost-full, computed in the write clock domain.

The almost-empty and almost-full thresholds come from two offset registers. Both offsets are 7 after reset.

The write port has a dual-purpose pin, `wr_en2_ld`. The block captures its level during reset, and that level fixes its role until the next reset:

- **High during reset (two-enable mode):** the pin is a second write enable.
- **Low during reset (programmable mode):** the pin is a load strobe. While it is low, write cycles store data-bus values into the two offset registers in a fixed rotation. Read cycles return the offsets on the read data bus in the same rotation, and do not remove any word from the buffer.

An output-enable input gates the read data. When disabled, the bus is forced to zero and a valid flag is dropped, in place of a three-state pad.

Top module: `prog_flag_fifo`

## Requirements
- R1: During a clock edge with `rst_n` low, both pointers return to the first location. After that edge `empty_n` and `aempty_n` are 0, `full_n` and `afull_n` are 1, and the read data register holds 0.
- R2: If `wr_en2_ld` is 1 during reset (two-enable mode), a word is stored only on a write-clock edge with `wr_en1_n`=0 and `wr_en2_ld`=1. In this mode `wr_en2_ld`=0 never loads or returns an offset.
- R3: If `wr_en2_ld` is 0 during reset (programmable mode), a write-clock edge with `wr_en1_n`=0 and `wr_en2_ld`=1 stores a word.
- R4: Words leave in the order they were written. A word is popped into the read data register only on a read-clock edge with `rd_en1_n`=0 and `rd_en2_n`=0. Otherwise the register holds its value.
- R5: Writes are ignored while `full_n` is 0. The stored count never exceeds the depth.
- R6: Reads are ignored while `empty_n` is 0, and the read data register keeps its value.
- R7: `aempty_n` is 0 exactly when the stored count is at most the empty offset. `afull_n` is 0 exactly when the free space is at most the full offset. Both offsets are 7 after reset. A low full or empty flag implies the matching almost flag is low.
- R8: In programmable mode, each write-clock edge with `wr_en1_n`=0 and `wr_en2_ld`=0 loads `wr_data[ADDR_W-1:0]` into the next offset register. The rotation is empty offset, then full offset, then back to the empty offset. The buffer contents are untouched.
- R9: In programmable mode, each read-clock edge with both read enables 0 and `wr_en2_ld`=0 places the next offset, zero-extended, in the read data register. It uses the same rotation and its own position, and does not pop a word.
- R10: With `out_en_n`=1, `rd_data` is 0 and `rd_data_vld` is 0. With `out_en_n`=0, `rd_data` shows the read data register and `rd_data_vld` is 1.
- R11: Reset returns both offset rotations to the empty offset and restores both offsets to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled on both clocks |
| wr_en1_n | input | 1 | Active-low primary write enable |
| wr_en2_ld | input | 1 | Second write enable, or offset load strobe (active low); role captured at reset |
| wr_data | input | 9 | Write word, or offset value in its low bits |
| full_n | output | 1 | Active-low full flag (write domain) |
| afull_n | output | 1 | Active-low almost-full flag (write domain) |
| rd_en1_n | input | 1 | Active-low read enable one |
| rd_en2_n | input | 1 | Active-low read enable two |
| out_en_n | input | 1 | Active-low output enable for the read data |
| rd_data | output | 9 | Read word or offset readback; zero when output is disabled |
| rd_data_vld | output | 1 | High when the read data is being driven |
| empty_n | output | 1 | Active-low empty flag (read domain) |
| aempty_n | output | 1 | Active-low almost-empty flag (read domain) |

## Verification
The properties assume `rst_n` is held low across at least one edge of each clock before any traffic. They also assume the load pin and the offsets are not changed on the same cycle as a readback, because readback samples the write-side offset registers directly. The bench ties both clocks together and builds the single-clock variant, so flag timing can be predicted cycle by cycle. Every input changes only on the falling edge. Offset loads and readbacks are never issued in the same cycle.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
    // Role of the shared enable/load pin, captured during reset
    typedef enum logic {
        MODE_TWO_EN = 1'b0,
        MODE_PROG   = 1'b1
    } mode_e;

    // Position in the offset register rotation
    typedef enum logic {
        SEL_AEMPTY = 1'b0,
        SEL_AFULL  = 1'b1
    } off_sel_e;
endpackage

// File: rtl/fifo_ram.sv
module fifo_ram #(
    parameter int AW = 4,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fifo_ptr_sync.sv
module fifo_ptr_sync #(
    parameter int W      = 5,
    parameter bit BYPASS = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] gray_seen;

    generate
        if (BYPASS) begin : g_direct
            assign gray_seen = gray_in;
        end else begin : g_two_flop
            logic [W-1:0] meta_q, meta_d;
            logic [W-1:0] stab_q, stab_d;
            always_comb begin
                meta_d = rst_n ? gray_in : '0;
                stab_d = rst_n ? meta_q  : '0;
            end
            always_ff @(posedge clk) begin
                meta_q <= meta_d;
                stab_q <= stab_d;
            end
            assign gray_seen = stab_q;
        end
    endgenerate

    // Gray to binary: each bit is the parity of itself and all higher bits
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(gray_seen >> i);
        end
    end
endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl
    import fifo_pkg::*;
#(
    parameter int              AW       = 4,
    parameter logic [AW-1:0]   OFF_INIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en1_n,
    input  logic          en2_ld,
    input  logic [AW-1:0] off_din,
    input  logic [AW:0]   rd_ptr_bin,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   ptr_bin,
    output logic [AW:0]   ptr_gray,
    output logic          full_n,
    output logic          afull_n,
    output mode_e         mode,
    output logic [AW-1:0] off_ae,
    output logic [AW-1:0] off_af
);
    localparam logic [AW:0] DEPTH = (AW+1)'(1) << AW;

    typedef struct packed {
        logic [AW:0]   ptr;
        logic [AW:0]   gray;
        mode_e         mode;
        off_sel_e      sel;
        logic [AW-1:0] off_ae;
        logic [AW-1:0] off_af;
    } wst_t;

    wst_t        s_d, s_q;
    logic [AW:0] fill, free, ptr_inc;
    logic        is_full, push, load;

    assign fill    = s_q.ptr - rd_ptr_bin;
    assign free    = DEPTH - fill;
    assign is_full = (fill == DEPTH);
    assign push    = rst_n && !en1_n && en2_ld && !is_full;
    assign load    = (s_q.mode == MODE_PROG) && !en1_n && !en2_ld;
    assign ptr_inc = s_q.ptr + 1'b1;

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.ptr  = ptr_inc;
            s_d.gray = ptr_inc ^ (ptr_inc >> 1);
        end
        if (load) begin
            if (s_q.sel == SEL_AEMPTY) begin
                s_d.off_ae = off_din;
                s_d.sel    = SEL_AFULL;
            end else begin
                s_d.off_af = off_din;
                s_d.sel    = SEL_AEMPTY;
            end
        end
        if (!rst_n) begin
            s_d.ptr    = '0;
            s_d.gray   = '0;
            s_d.mode   = en2_ld ? MODE_TWO_EN : MODE_PROG;
            s_d.sel    = SEL_AEMPTY;
            s_d.off_ae = OFF_INIT;
            s_d.off_af = OFF_INIT;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign we       = push;
    assign waddr    = s_q.ptr[AW-1:0];
    assign ptr_bin  = s_q.ptr;
    assign ptr_gray = s_q.gray;
    assign full_n   = !is_full;
    assign afull_n  = !(free <= {1'b0, s_q.off_af});
    assign mode     = s_q.mode;
    assign off_ae   = s_q.off_ae;
    assign off_af   = s_q.off_af;
endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl
    import fifo_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en1_n,
    input  logic          en2_n,
    input  logic          ld_n,
    input  mode_e         mode,
    input  logic [AW:0]   wr_ptr_bin,
    input  logic [AW-1:0] off_ae,
    input  logic [AW-1:0] off_af,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   ptr_bin,
    output logic [AW:0]   ptr_gray,
    output logic          empty_n,
    output logic          aempty_n,
    output logic [DW-1:0] dout
);
    typedef struct packed {
        logic [AW:0]   ptr;
        logic [AW:0]   gray;
        off_sel_e      sel;
        logic [DW-1:0] dout;
    } rst_t;

    rst_t        s_d, s_q;
    logic [AW:0] fill, ptr_inc;
    logic        is_empty, rd_req, readback, pop;

    assign fill     = wr_ptr_bin - s_q.ptr;
    assign is_empty = (fill == '0);
    assign rd_req   = !en1_n && !en2_n;
    assign readback = rd_req && (mode == MODE_PROG) && !ld_n;
    assign pop      = rd_req && !readback && !is_empty;
    assign ptr_inc  = s_q.ptr + 1'b1;

    always_comb begin
        s_d = s_q;
        if (pop) begin
            s_d.ptr  = ptr_inc;
            s_d.gray = ptr_inc ^ (ptr_inc >> 1);
            s_d.dout = mem_rdata;
        end
        if (readback) begin
            if (s_q.sel == SEL_AEMPTY) begin
                s_d.dout = DW'(off_ae);
                s_d.sel  = SEL_AFULL;
            end else begin
                s_d.dout = DW'(off_af);
                s_d.sel  = SEL_AEMPTY;
            end
        end
        if (!rst_n) begin
            s_d.ptr  = '0;
            s_d.gray = '0;
            s_d.sel  = SEL_AEMPTY;
            s_d.dout = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign raddr    = s_q.ptr[AW-1:0];
    assign ptr_bin  = s_q.ptr;
    assign ptr_gray = s_q.gray;
    assign empty_n  = !is_empty;
    assign aempty_n = !(fill <= {1'b0, off_ae});
    assign dout     = s_q.dout;
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
    import fifo_pkg::*;
#(
    parameter int            DATA_W     = 9,
    parameter int            ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] OFFSET_INIT = 7,
    parameter bit            SINGLE_CLK = 1'b0
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en1_n,
    input  logic              wr_en2_ld,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              afull_n,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_data_vld,
    output logic              empty_n,
    output logic              aempty_n
);
    logic [ADDR_W:0]   wr_ptr_bin, wr_ptr_gray, wr_ptr_at_rd;
    logic [ADDR_W:0]   rd_ptr_bin, rd_ptr_gray, rd_ptr_at_wr;
    logic [ADDR_W-1:0] waddr, raddr, off_ae, off_af;
    logic [DATA_W-1:0] mem_rdata, dout_q;
    logic              mem_we;
    mode_e             mode;

    fifo_wr_ctrl #(.AW(ADDR_W), .OFF_INIT(OFFSET_INIT)) u_wr (
        .clk       (wr_clk),
        .rst_n     (rst_n),
        .en1_n     (wr_en1_n),
        .en2_ld    (wr_en2_ld),
        .off_din   (wr_data[ADDR_W-1:0]),
        .rd_ptr_bin(rd_ptr_at_wr),
        .we        (mem_we),
        .waddr     (waddr),
        .ptr_bin   (wr_ptr_bin),
        .ptr_gray  (wr_ptr_gray),
        .full_n    (full_n),
        .afull_n   (afull_n),
        .mode      (mode),
        .off_ae    (off_ae),
        .off_af    (off_af)
    );

    fifo_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk  (wr_clk),
        .we   (mem_we),
        .waddr(waddr),
        .wdata(wr_data),
        .raddr(raddr),
        .rdata(mem_rdata)
    );

    fifo_ptr_sync #(.W(ADDR_W+1), .BYPASS(SINGLE_CLK)) u_wr2rd (
        .clk    (rd_clk),
        .rst_n  (rst_n),
        .gray_in(wr_ptr_gray),
        .bin_out(wr_ptr_at_rd)
    );

    fifo_ptr_sync #(.W(ADDR_W+1), .BYPASS(SINGLE_CLK)) u_rd2wr (
        .clk    (wr_clk),
        .rst_n  (rst_n),
        .gray_in(rd_ptr_gray),
        .bin_out(rd_ptr_at_wr)
    );

    fifo_rd_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rst_n),
        .en1_n     (rd_en1_n),
        .en2_n     (rd_en2_n),
        .ld_n      (wr_en2_ld),
        .mode      (mode),
        .wr_ptr_bin(wr_ptr_at_rd),
        .off_ae    (off_ae),
        .off_af    (off_af),
        .mem_rdata (mem_rdata),
        .raddr     (raddr),
        .ptr_bin   (rd_ptr_bin),
        .ptr_gray  (rd_ptr_gray),
        .empty_n   (empty_n),
        .aempty_n  (aempty_n),
        .dout      (dout_q)
    );

    assign rd_data     = out_en_n ? '0 : dout_q;
    assign rd_data_vld = !out_en_n;
endmodule

// File: rtl/fifo_chk.sv
module fifo_chk
    import fifo_pkg::*;
#(
    parameter int AW = 4
) (
    input logic        wr_clk,
    input logic        rd_clk,
    input logic        rst_n,
    input logic        wr_en1_n,
    input logic        wr_en2_ld,
    input mode_e       mode,
    input logic        full_n,
    input logic        afull_n,
    input logic        empty_n,
    input logic        aempty_n,
    input logic [AW:0] wr_ptr,
    input logic [AW:0] rd_ptr,
    input logic [AW:0] rd_ptr_w
);
    localparam logic [AW:0] DEPTH = (AW+1)'(1) << AW;

    // R1
    rst_wr_flags_chk: assert property (@(posedge wr_clk)
        !rst_n |=> (full_n && afull_n));

    // R1
    rst_rd_flags_chk: assert property (@(posedge rd_clk)
        !rst_n |=> (!empty_n && !aempty_n));

    // R2
    two_en_gate_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (mode == MODE_TWO_EN && !wr_en2_ld) |=> $stable(wr_ptr));

    // R5
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n && !wr_en1_n) |=> $stable(wr_ptr));

    // R5
    fill_bound_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_ptr - rd_ptr_w) <= DEPTH);

    // R6
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> $stable(rd_ptr));

    // R7
    full_implies_afull_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    // R7
    empty_implies_aempty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);
endmodule

bind prog_flag_fifo fifo_chk #(.AW(ADDR_W)) u_chk (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .rst_n    (rst_n),
    .wr_en1_n (wr_en1_n),
    .wr_en2_ld(wr_en2_ld),
    .mode     (mode),
    .full_n   (full_n),
    .afull_n  (afull_n),
    .empty_n  (empty_n),
    .aempty_n (aempty_n),
    .wr_ptr   (wr_ptr_bin),
    .rd_ptr   (rd_ptr_bin),
    .rd_ptr_w (rd_ptr_at_wr)
);

// File: tb/prog_flag_fifo_tb.sv
module prog_flag_fifo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 9;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en1_n = 1'b1;
    logic          wr_en2_ld = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en1_n = 1'b1;
    logic          rd_en2_n = 1'b1;
    logic          out_en_n = 1'b0;
    logic          full_n, afull_n, empty_n, aempty_n, rd_data_vld;
    logic [DW-1:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_flag_fifo #(.DATA_W(DW), .ADDR_W(AW), .OFFSET_INIT(7), .SINGLE_CLK(1'b1)) u_dut (
        .wr_clk     (clk),
        .rd_clk     (clk),
        .rst_n      (rst_n),
        .wr_en1_n   (wr_en1_n),
        .wr_en2_ld  (wr_en2_ld),
        .wr_data    (wr_data),
        .full_n     (full_n),
        .afull_n    (afull_n),
        .rd_en1_n   (rd_en1_n),
        .rd_en2_n   (rd_en2_n),
        .out_en_n   (out_en_n),
        .rd_data    (rd_data),
        .rd_data_vld(rd_data_vld),
        .empty_n    (empty_n),
        .aempty_n   (aempty_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive at falling edge, return at next falling edge, then idle
    task automatic cyc(input logic e1, input logic e2, input logic [DW-1:0] d,
                       input logic r1, input logic r2);
        wr_en1_n  = e1;
        wr_en2_ld = e2;
        wr_data   = d;
        rd_en1_n  = r1;
        rd_en2_n  = r2;
        @(posedge clk);
        @(negedge clk);
        wr_en1_n  = 1'b1;
        wr_en2_ld = 1'b1;
        rd_en1_n  = 1'b1;
        rd_en2_n  = 1'b1;
    endtask

    task automatic do_reset(input logic pin);
        rst_n     = 1'b0;
        wr_en2_ld = pin;
        wr_en1_n  = 1'b1;
        rd_en1_n  = 1'b1;
        rd_en2_n  = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n     = 1'b1;
        wr_en2_ld = 1'b1;
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 37 + 5) & 9'h1FF);
    endfunction

    task automatic t_reset_state();
        do_reset(1'b1);
        chk("R1 empty_n",  32'(empty_n),  0);
        chk("R1 aempty_n", 32'(aempty_n), 0);
        chk("R1 full_n",   32'(full_n),   1);
        chk("R1 afull_n",  32'(afull_n),  1);
        chk("R1 rd_data",  32'(rd_data),  0);
    endtask

    task automatic t_two_enable();
        do_reset(1'b1);
        cyc(1'b0, 1'b0, 9'h1A5, 1'b1, 1'b1);
        chk("R2 en2 low blocks write", 32'(empty_n), 0);
        cyc(1'b0, 1'b1, 9'h1A5, 1'b1, 1'b1);
        chk("R2 qualified write", 32'(empty_n), 1);
        cyc(1'b1, 1'b1, '0, 1'b0, 1'b1);
        chk("R4 single read enable no pop", 32'(rd_data), 0);
        cyc(1'b1, 1'b1, '0, 1'b0, 1'b0);
        chk("R4 pop data", 32'(rd_data), 32'h1A5);
        chk("R4 empty after pop", 32'(empty_n), 0);
        cyc(1'b1, 1'b0, '0, 1'b0, 1'b0);
        chk("R2 load pin low no readback", 32'(rd_data), 32'h1A5);
        out_en_n = 1'b1;
        #1;
        chk("R10 disabled data", 32'(rd_data), 0);
        chk("R10 disabled vld",  32'(rd_data_vld), 0);
        out_en_n = 1'b0;
        #1;
        chk("R10 enabled data", 32'(rd_data), 32'h1A5);
        chk("R10 enabled vld",  32'(rd_data_vld), 1);
    endtask

    task automatic t_fill_drain();
        do_reset(1'b1);
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1'b0, 1'b1, pat(i), 1'b1, 1'b1);
            chk("R7 aempty_n", 32'(aempty_n), 32'((i + 1) > 7));
            chk("R7 afull_n",  32'(afull_n),  32'((DEPTH - (i + 1)) > 7));
        end
        chk("R5 full at depth", 32'(full_n), 0);
        cyc(1'b0, 1'b1, 9'h0AA, 1'b1, 1'b1);
        chk("R5 still full", 32'(full_n), 0);
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1'b1, 1'b1, '0, 1'b0, 1'b0);
            chk("R4 order", 32'(rd_data), 32'(pat(i)));
        end
        chk("R5 overflow word dropped", 32'(empty_n), 0);
        cyc(1'b1, 1'b1, '0, 1'b0, 1'b0);
        chk("R6 empty read holds", 32'(rd_data), 32'(pat(DEPTH - 1)));
    endtask

    task automatic t_prog_offsets();
        do_reset(1'b0);
        cyc(1'b0, 1'b0, 9'd3,  1'b1, 1'b1);
        cyc(1'b0, 1'b0, 9'd12, 1'b1, 1'b1);
        chk("R8 load leaves buffer empty", 32'(empty_n), 0);
        cyc(1'b1, 1'b0, '0, 1'b0, 1'b0);
        chk("R9 readback empty offset", 32'(rd_data), 3);
        cyc(1'b1, 1'b0, '0, 1'b0, 1'b0);
        chk("R9 readback full offset", 32'(rd_data), 12);
        cyc(1'b1, 1'b0, '0, 1'b0, 1'b0);
        chk("R9 readback wraps", 32'(rd_data), 3);
        cyc(1'b0, 1'b0, 9'd5, 1'b1, 1'b1);
        cyc(1'b1, 1'b0, '0, 1'b0, 1'b0);
        chk("R9 readback full offset again", 32'(rd_data), 12);
        cyc(1'b1, 1'b0, '0, 1'b0, 1'b0);
        chk("R8 third load wrapped to empty offset", 32'(rd_data), 5);
        for (int c = 1; c <= 6; c++) begin
            cyc(1'b0, 1'b1, DW'(9'h40 + c), 1'b1, 1'b1);
            chk("R3 write in programmable mode", 32'(empty_n), 1);
            chk("R8 aempty_n from loaded offset", 32'(aempty_n), 32'(c > 5));
            chk("R8 afull_n from loaded offset",  32'(afull_n),  32'(c < 4));
        end
        cyc(1'b1, 1'b1, '0, 1'b0, 1'b0);
        chk("R9 readback did not pop", 32'(rd_data), 32'h41);
    endtask

    task automatic t_offset_reset();
        do_reset(1'b0);
        cyc(1'b0, 1'b0, 9'd2, 1'b1, 1'b1);
        do_reset(1'b0);
        cyc(1'b0, 1'b0, 9'd9, 1'b1, 1'b1);
        cyc(1'b1, 1'b0, '0, 1'b0, 1'b0);
        chk("R11 rotation restarts at empty offset", 32'(rd_data), 9);
        cyc(1'b1, 1'b0, '0, 1'b0, 1'b0);
        chk("R11 full offset back to default", 32'(rd_data), 7);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_two_enable();
        t_fill_drain();
        t_prog_offsets();
        t_offset_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule